// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

This block controls a parameterised number of general-purpose pins, up to 128. The pins are split into 32-pin banks. Every control register exists once per bank. For each pin, software sets a drive value, a direction, an enable, an interrupt mask and an edge polarity. It also reads a synchronised copy of the pin level and a sticky interrupt status. All status bits are folded into one registered, active-high interrupt line.

Access is through a plain synchronous bus: a word address, a write strobe, write data, and read data that appears one cycle after the address. Two build options shape the block. `HAS_ENABLE` removes the per-pin enable register, so every pin counts as enabled. `HAS_EDGE_TYPE` removes the polarity register, so every pin interrupts on a high level. The last bank may be only partly filled; its unused bit positions carry no function.

There is no state machine: each bank is a set of registers with a next-state equation per register. The top level holds only the address decode, the read multiplexer and the interrupt register.

Top module: `gpio_ctrl`

## Requirements
- R1: The word address is `reg*16 + bank`, with `reg = addr[6:4]` and `bank = addr[3:0]`. Pin n sits in bank n/32 at bit n%32. The register codes are: 0 output data, 1 direction, 2 interrupt mask, 3 status, 4 edge type, 5 enable, 6 pin level (read-only). `bus_rdata` shows the addressed word on the cycle after the address is presented.
- R2: After reset, every valid bit of the direction and mask registers is 1. Output data, status, edge type and enable are 0, and `irq` and `pin_oe` are low.
- R3: `pin_out[n]` follows output-data bit n. `pin_oe[n]` is high exactly when pin n is enabled and its direction bit is 0 (1 means input).
- R4: A disabled pin never drives and never sets status. When `HAS_ENABLE`=0, every pin counts as enabled and the enable register reads 0.
- R5: The pin-level register returns the input after a two-flop synchroniser. A change at the input is first readable by a read whose address is presented two cycles later.
- R6: With edge-type bit 1, a rising synchronised edge sets status. With edge-type bit 0, a falling edge sets it. The status bit rises on the clock after the synchronised edge is seen.
- R7: When `HAS_EDGE_TYPE`=0, status is set on every clock where the synchronised level is high on an enabled, unmasked pin. The edge-type register then reads 0 and ignores writes.
- R8: A mask bit of 1 stops that pin from setting status. A mask bit of 0 lets it.
- R9: Writing the status register clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as a clear leaves the bit set.
- R10: `irq` equals the OR of all status bits one clock earlier.
- R11: Bit positions above `NUM_PINS`, banks beyond the last, and register code 7 read as 0. Writes to them change nothing, and they never raise status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Word address: register code and bank |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after address |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Drive values |
| pin_oe | output | NUM_PINS | Drive enables |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A single pin is toggled under each polarity, so a rising-only or falling-only decoder shows a wrong status where the other would not. A falling edge is timed to meet a status clear on the same clock, which separates a design where the event wins from one where the clear wins. Masked and unmasked pins move together, so a mask decoded with the wrong sense shows up. A level-sensitive build is held high across clears to show that status re-asserts. Writes of all ones to the partial last bank, to a missing bank and to code 7 show whether any state outside the pin range can be touched.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int WORD_W = 32;
    localparam int BANK_AW = 4;
    localparam int REG_AW = 3;
    localparam int ADDR_W = BANK_AW + REG_AW;

    typedef enum logic [REG_AW-1:0] {
        RG_OUT  = 3'd0,
        RG_DIR  = 3'd1,
        RG_MASK = 3'd2,
        RG_STAT = 3'd3,
        RG_EDGE = 3'd4,
        RG_ENAB = 3'd5,
        RG_PIN  = 3'd6,
        RG_NONE = 3'd7
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int VW       = 32,
    parameter bit HAS_EN   = 1'b1,
    parameter bit HAS_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  gpio_reg_e         reg_sel,
    input  logic [VW-1:0]     wr_data,
    input  logic [VW-1:0]     pin_in,
    output logic [VW-1:0]     out_data,
    output logic [VW-1:0]     out_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              stat_any
);
    logic [VW-1:0] lvl;
    logic [VW-1:0] outd_q, dir_q, msk_q, stat_q;
    logic [VW-1:0] trig, ena_eff, ena_rd, edg_rd, evt;
    logic wr_out, wr_dir, wr_msk, wr_stat, wr_edge, wr_ena;

    assign wr_out  = wr_en && (reg_sel == RG_OUT);
    assign wr_dir  = wr_en && (reg_sel == RG_DIR);
    assign wr_msk  = wr_en && (reg_sel == RG_MASK);
    assign wr_stat = wr_en && (reg_sel == RG_STAT);
    assign wr_edge = wr_en && (reg_sel == RG_EDGE);
    assign wr_ena  = wr_en && (reg_sel == RG_ENAB);

    gpio_sync #(.W(VW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outd_q <= '0;
            dir_q  <= '1;
            msk_q  <= '1;
        end else begin
            if (wr_out) outd_q <= wr_data;
            if (wr_dir) dir_q  <= wr_data;
            if (wr_msk) msk_q  <= wr_data;
        end
    end

    generate
        if (HAS_EN) begin : g_enable
            logic [VW-1:0] ena_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ena_q <= '0;
                else if (wr_ena) ena_q <= wr_data;
            end
            assign ena_eff = ena_q;
            assign ena_rd  = ena_q;
        end else begin : g_always_on
            assign ena_eff = '1;
            assign ena_rd  = '0;
        end

        if (HAS_EDGE) begin : g_edge
            logic [VW-1:0] edg_q, prv_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    edg_q <= '0;
                    prv_q <= '0;
                end else begin
                    if (wr_edge) edg_q <= wr_data;
                    prv_q <= lvl;
                end
            end
            assign trig   = (edg_q & lvl & ~prv_q) | (~edg_q & ~lvl & prv_q);
            assign edg_rd = edg_q;
        end else begin : g_level
            assign trig   = lvl;
            assign edg_rd = '0;
        end
    endgenerate

    assign evt = ena_eff & ~msk_q & trig;

    // a fresh event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & (wr_stat ? wr_data : '1)) | evt;
    end

    assign out_data = outd_q;
    assign out_en   = ena_eff & ~dir_q;
    assign stat_any = |stat_q;

    always_comb begin
        unique case (reg_sel)
            RG_OUT:  rd_word = WORD_W'(outd_q);
            RG_DIR:  rd_word = WORD_W'(dir_q);
            RG_MASK: rd_word = WORD_W'(msk_q);
            RG_STAT: rd_word = WORD_W'(stat_q);
            RG_EDGE: rd_word = WORD_W'(edg_rd);
            RG_ENAB: rd_word = WORD_W'(ena_rd);
            RG_PIN:  rd_word = WORD_W'(lvl);
            default: rd_word = '0;
        endcase
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R9

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~stat_q & $past(stat_q)) & ~($past(wr_stat) ? ~$past(wr_data) : '0)) == '0); // R9

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & $past(msk_q)) == '0); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q)) & ~$past(ena_eff)) == '0); // R4
endmodule

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS      = 40,
    parameter bit HAS_ENABLE    = 1'b1,
    parameter bit HAS_EDGE_TYPE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

    gpio_reg_e            reg_sel;
    logic [BANK_AW-1:0]   bank_idx;
    logic [WORD_W-1:0]    rd_word [BANKS];
    logic [BANKS-1:0]     stat_any;
    logic [WORD_W-1:0]    rd_sel;

    assign reg_sel  = gpio_reg_e'(bus_addr[ADDR_W-1:BANK_AW]);
    assign bank_idx = bus_addr[BANK_AW-1:0];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            localparam int VB = (b == BANKS - 1) ? NUM_PINS - WORD_W * b : WORD_W;
            gpio_bank #(
                .VW       (VB),
                .HAS_EN   (HAS_ENABLE),
                .HAS_EDGE (HAS_EDGE_TYPE)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bus_we && (bank_idx == BANK_AW'(b))),
                .reg_sel  (reg_sel),
                .wr_data  (bus_wdata[VB-1:0]),
                .pin_in   (pin_in[b*WORD_W +: VB]),
                .out_data (pin_out[b*WORD_W +: VB]),
                .out_en   (pin_oe[b*WORD_W +: VB]),
                .rd_word  (rd_word[b]),
                .stat_any (stat_any[b])
            );
        end
    endgenerate

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_idx == BANK_AW'(b)) rd_sel = rd_word[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            bus_rdata <= rd_sel;
            irq       <= |stat_any;
        end
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|stat_any)); // R10
endmodule

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;
    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [NP-1:0] pins = '0;
    logic [31:0]   rdata0, rdata1;
    logic [NP-1:0] pout0, poe0, pout1, poe1;
    logic          irq0, irq1;

    int checks = 0;
    int fails  = 0;
    logic [31:0] r0, r1;

    always #2.5 clk = ~clk;

    gpio_ctrl #(.NUM_PINS(NP), .HAS_ENABLE(1'b1), .HAS_EDGE_TYPE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata0), .pin_in(pins), .pin_out(pout0), .pin_oe(poe0), .irq(irq0));

    gpio_ctrl #(.NUM_PINS(NP), .HAS_ENABLE(1'b0), .HAS_EDGE_TYPE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata1), .pin_in(pins), .pin_out(pout1), .pin_oe(poe1), .irq(irq1));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of u0, one pin at a time
    logic [NP-1:0] m_out, m_dir, m_msk, m_stat, m_edge, m_en, m_s1, m_s2, m_prev;
    logic          m_irq;
    logic [31:0]   m_rd;

    function automatic logic [31:0] model_read(input int rg, input int bk);
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            if (p / 32 == bk) begin
                case (rg)
                    0: v[p % 32] = m_out[p];
                    1: v[p % 32] = m_dir[p];
                    2: v[p % 32] = m_msk[p];
                    3: v[p % 32] = m_stat[p];
                    4: v[p % 32] = m_edge[p];
                    5: v[p % 32] = m_en[p];
                    6: v[p % 32] = m_s2[p];
                    default: v[p % 32] = 1'b0;
                endcase
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '1; m_msk = '1; m_stat = '0; m_edge = '0;
            m_en = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 1'b0; m_rd = '0;
        end else begin
            int rg, bk;
            rg = int'(addr) / 16;
            bk = int'(addr) % 16;
            m_rd  = model_read(rg, bk);
            m_irq = |m_stat;
            for (int p = 0; p < NP; p++) begin
                bit hit, ev, ns, b;
                hit = we && (bk == p / 32);
                b   = wdata[p % 32];
                if (m_edge[p]) ev = m_s2[p] && !m_prev[p];
                else           ev = !m_s2[p] && m_prev[p];
                ev = ev && m_en[p] && !m_msk[p];
                ns = (m_stat[p] && !(hit && rg == 3 && !b)) || ev;
                if (hit) begin
                    case (rg)
                        0: m_out[p]  = b;
                        1: m_dir[p]  = b;
                        2: m_msk[p]  = b;
                        4: m_edge[p] = b;
                        5: m_en[p]   = b;
                        default: ;
                    endcase
                end
                m_stat[p] = ns;
                m_prev[p] = m_s2[p];
                m_s2[p]   = m_s1[p];
                m_s1[p]   = pins[p];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model pin_out", 64'(pout0), 64'(m_out));
            chk("R3 model pin_oe", 64'(poe0), 64'(m_en & ~m_dir));
            chk("R10 model irq", 64'(irq0), 64'(m_irq));
            chk("R1 model rdata", 64'(rdata0), 64'(m_rd));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); addr = 7'(a); we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk); addr = 7'(a); we = 1'b0;
        @(negedge clk); r0 = rdata0; r1 = rdata1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input int p, input logic v);
        @(negedge clk); pins[p] = v;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        chk("R2 irq after reset", 64'(irq0), 64'd0);
        chk("R2 oe after reset", 64'(poe0), 64'd0);
        rd(1*16+0); chk("R2 dir bank0", 64'(r0), 64'hFFFFFFFF);
        rd(1*16+1); chk("R2 R11 dir bank1 partial", 64'(r0), 64'h000000FF);
        rd(2*16+1); chk("R2 mask bank1", 64'(r0), 64'h000000FF);
        rd(3*16+0); chk("R2 status bank0", 64'(r0), 64'd0);

        // R3/R4 drive control
        wr(0*16+0, 32'h000000A5);
        wr(1*16+0, 32'hFFFFFF00);
        idle(1);
        chk("R4 disabled pins do not drive", 64'(poe0[7:0]), 64'd0);
        chk("R4 absent enable drives", 64'(poe1[7:0]), 64'hFF);
        wr(5*16+0, 32'h0000000F);
        idle(1);
        chk("R3 oe enabled outputs", 64'(poe0[7:0]), 64'h0F);
        chk("R3 output data", 64'(pout0[7:0]), 64'hA5);

        // R5 synchroniser latency, R1 pin 33 at bank1 bit1
        setpin(33, 1'b1);
        rd(6*16+1); chk("R5 level not yet visible", 64'(r0), 64'd0);
        rd(6*16+1); chk("R5 R1 level visible", 64'(r0), 64'h2);

        // R6 rising edge on pin 32, pin 33 stays masked (R8)
        wr(5*16+1, 32'hFF);
        wr(4*16+1, 32'h1);
        wr(2*16+1, 32'hFFFFFFFE);
        setpin(32, 1'b1);
        idle(4);
        rd(3*16+1); chk("R6 R8 rising sets only unmasked pin", 64'(r0), 64'h1);
        chk("R10 irq high", 64'(irq0), 64'd1);

        // R9 clear by writing zero
        wr(3*16+1, 32'hFFFFFFFE);
        rd(3*16+1); chk("R9 cleared", 64'(r0), 64'd0);
        idle(1);
        chk("R10 irq low after clear", 64'(irq0), 64'd0);

        // R6 falling ignored in rising mode, then falling mode
        setpin(32, 1'b0);
        idle(4);
        rd(3*16+1); chk("R6 falling ignored when rising selected", 64'(r0), 64'd0);
        wr(4*16+1, 32'h0);
        setpin(32, 1'b1);
        idle(4);
        rd(3*16+1); chk("R6 rising ignored when falling selected", 64'(r0), 64'd0);
        setpin(32, 1'b0);
        idle(4);
        rd(3*16+1); chk("R6 falling sets status", 64'(r0), 64'h1);

        // R9 event in the same cycle as a clear wins
        setpin(32, 1'b1);
        idle(4);
        @(negedge clk); pins[32] = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 7'(3*16+1); we = 1'b1; wdata = 32'hFFFFFFFE;
        @(negedge clk); we = 1'b0;
        rd(3*16+1); chk("R9 event beats clear", 64'(r0), 64'h1);
        wr(3*16+1, 32'hFFFFFFFE);
        wr(3*16+1, 32'hFFFFFFFF);
        rd(3*16+1); chk("R9 writing ones sets nothing", 64'(r0), 64'd0);

        // R11 unused bits, banks and codes
        wr(0*16+1, 32'hFFFFFFFF);
        rd(0*16+1); chk("R11 partial bank masks write", 64'(r0), 64'hFF);
        chk("R11 R3 upper pins driven", 64'(pout0[39:32]), 64'hFF);
        wr(7*16+0, 32'hFFFFFFFF);
        rd(7*16+0); chk("R11 code 7 reads zero", 64'(r0), 64'd0);
        wr(0*16+3, 32'hFFFFFFFF);
        rd(0*16+3); chk("R11 missing bank reads zero", 64'(r0), 64'd0);
        rd(0*16+0); chk("R11 bank0 untouched", 64'(r0), 64'hA5);

        // R7 level mode on u1 (pin 32 low now, status cleared)
        rd(3*16+1); chk("R7 level status idle", 64'(r1), 64'd0);
        setpin(32, 1'b1);
        idle(4);
        wr(3*16+1, 32'hFFFFFFFE);
        idle(2);
        rd(3*16+1); chk("R7 level reasserts after clear", 64'(r1), 64'h1);
        chk("R7 R10 level irq", 64'(irq1), 64'd1);
        setpin(32, 1'b0);
        idle(4);
        wr(3*16+1, 32'hFFFFFFFE);
        idle(2);
        rd(3*16+1); chk("R7 low level stays clear", 64'(r1), 64'd0);
        wr(4*16+1, 32'hFF);
        rd(4*16+1);
        chk("R7 edge register absent", 64'(r1), 64'd0);
        chk("R6 edge register present", 64'(r0), 64'hFF);
        rd(5*16+1); chk("R4 enable register absent reads zero", 64'(r1), 64'd0);

        idle(2);
        finish_run();
    end
endmodule